// File: doc/BRIEF.md
# Audio Bit-Clock and Frame-Clock Divider

This block runs on the audio master clock and derives from it the serial bit clock and the word-select (frame) clock. It also produces a gated copy of the master clock. A ten-bit configuration word carries four things: a bit-clock ratio code, a frame-length code, a clock enable and a soft reset for the channel. The bit clock is the master clock divided by 4 or 8. The word-select clock is the bit clock divided by a frame length chosen from a fixed set between 8 and 256 bit clocks.

Besides the clocks, the block issues single-cycle strobes in the master-clock domain. The serial shifters use these strobes instead of treating the derived clocks as clocks. A strobe marks each rising and each falling bit-clock edge, the start of the right-channel half, and the start of each frame.

Ratio codes are latched while the channel is idle and are then picked up again only at frame boundaries. A reprogram during operation therefore never produces a short bit-clock pulse or a short frame. Codes outside the supported set fall back to safe defaults and raise a sticky error flag.

Top module: `audio_clk_div`

## Requirements
- R1: The bit-clock code in cfg_i[3:0] selects the division of the master clock: 3 gives 4 and 5 gives 8. After enabling, bclk_o is low for the first half of each period and high for the second half, giving a 50% duty cycle.
- R2: The frame code in cfg_i[6:4] selects the bit clocks per frame: 0→16, 1→32, 2→48, 3→64, 4→128, 5→256, 6→8. ws_o is low for the first half of the frame (left) and high for the second half (right). ws_o changes only together with a bit-clock falling edge.
- R3: bclk_rise_o and bclk_fall_o are one master-clock cycle long and coincide with the first cycle of bclk_o high and low respectively. ws_rise_o marks the first cycle of ws_o high. frame_start_o marks the first cycle of each new frame reached by counting.
- R4: With cfg_i[8] (enable) low, bclk_o, ws_o and all strobes are 0, the counters are cleared, and mclk_o stays low. mclk_o follows the enable with one master-clock cycle of latency and changes only while the master clock is low.
- R5: With cfg_i[9] (soft reset) high, the channel behaves as disabled whatever the enable bit says. On release it restarts from the start of a frame.
- R6: A bit-clock code other than 3 or 5 selects division by 4. Frame code 7 selects a 64-bit frame.
- R7: cfg_err_o sets in any cycle with soft reset low and an unsupported bit-clock code, frame code 7, or reserved bit cfg_i[7] set. It stays set until soft reset or rst_i.
- R8: Codes changed while running take effect only at the next frame boundary. Codes present while idle are the ones used from the first enabled cycle.
- R9: A synchronous active-high rst_i clears all outputs and counters and selects division by 4 with a 64-bit frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock; all logic runs on it |
| rst_i | input | 1 | Synchronous active-high reset |
| cfg_i | input | 10 | Configuration: [9] soft reset, [8] enable, [7] reserved, [6:4] frame code, [3:0] bit-clock code |
| mclk_o | output | 1 | Gated master clock |
| bclk_o | output | 1 | Serial bit clock |
| ws_o | output | 1 | Word-select clock, high in the right-channel half |
| bclk_rise_o | output | 1 | Strobe on the first cycle of bit clock high |
| bclk_fall_o | output | 1 | Strobe on the first cycle of bit clock low |
| ws_rise_o | output | 1 | Strobe on the first cycle of word select high |
| frame_start_o | output | 1 | Strobe on the first cycle of a new frame |
| cfg_err_o | output | 1 | Sticky unsupported-configuration flag |

## Verification
The embedded properties assume that cfg_i is synchronous to the master clock and settled around each rising edge. They also assume that rst_i is applied at some edge before the outputs are relied upon. The stimulus changes cfg_i and rst_i only on the falling edge and holds reset across the first edges. Before each new pair of codes is enabled, the channel spends one idle cycle, so the codes under test are the latched ones. The one exception is a deliberate mid-run change, which checks the frame-boundary hand-over.

// File: rtl/aclk_pkg.sv
package aclk_pkg;

    localparam int CFG_W  = 10;
    localparam int CODE_W = 4;
    localparam int FSEL_W = 3;
    localparam int DIV_W  = 4;   // holds the largest division, 8
    localparam int LEN_W  = 9;   // holds the longest frame, 256

    localparam logic [DIV_W-1:0] DEF_DIV = DIV_W'(4);
    localparam logic [LEN_W-1:0] DEF_LEN = LEN_W'(64);

    typedef enum logic [FSEL_W-1:0] {
        FRM_16  = 3'd0,
        FRM_32  = 3'd1,
        FRM_48  = 3'd2,
        FRM_64  = 3'd3,
        FRM_128 = 3'd4,
        FRM_256 = 3'd5,
        FRM_8   = 3'd6,
        FRM_BAD = 3'd7
    } frm_code_e;

    localparam logic [CODE_W-1:0] BCODE_DIV4 = 4'd3;
    localparam logic [CODE_W-1:0] BCODE_DIV8 = 4'd5;

    typedef struct packed {
        logic              soft_rst;
        logic              clk_en;
        logic              rsv;
        logic [FSEL_W-1:0] frm_code;
        logic [CODE_W-1:0] bdiv_code;
    } cfg_t;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [LEN_W-1:0] len;
    } ratio_t;

    function automatic logic [DIV_W-1:0] bclk_ratio(input logic [CODE_W-1:0] code);
        case (code)
            BCODE_DIV8: return DIV_W'(8);
            default:    return DEF_DIV;
        endcase
    endfunction

    function automatic logic [LEN_W-1:0] frame_bits(input logic [FSEL_W-1:0] code);
        case (frm_code_e'(code))
            FRM_16:  return LEN_W'(16);
            FRM_32:  return LEN_W'(32);
            FRM_48:  return LEN_W'(48);
            FRM_64:  return LEN_W'(64);
            FRM_128: return LEN_W'(128);
            FRM_256: return LEN_W'(256);
            FRM_8:   return LEN_W'(8);
            default: return DEF_LEN;
        endcase
    endfunction

    function automatic logic codes_ok(input cfg_t c);
        return ((c.bdiv_code == BCODE_DIV4) || (c.bdiv_code == BCODE_DIV8))
            && (frm_code_e'(c.frm_code) != FRM_BAD) && !c.rsv;
    endfunction

endpackage

// File: rtl/aclk_decode.sv
module aclk_decode
    import aclk_pkg::*;
(
    input  cfg_t   cfg_i,
    output ratio_t ratio_o,
    output logic   bad_o
);
    always_comb begin
        ratio_o.div = bclk_ratio(cfg_i.bdiv_code);
        ratio_o.len = frame_bits(cfg_i.frm_code);
        bad_o       = !codes_ok(cfg_i);
    end
endmodule

// File: rtl/aclk_bit_ctr.sv
module aclk_bit_ctr #(
    parameter int W = aclk_pkg::DIV_W
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         clr_i,
    input  logic [W-1:0] div_i,
    output logic         wrap_o,
    output logic         bclk_o,
    output logic         rise_o,
    output logic         fall_o
);
    logic [W-1:0] mc_q;
    logic [W-1:0] mc_nx;
    logic [W-1:0] half;

    assign half   = div_i >> 1;
    assign wrap_o = (mc_q == div_i - 1'b1);
    assign mc_nx  = wrap_o ? '0 : mc_q + 1'b1;

    always_ff @(posedge clk_i) begin
        if (rst_i || clr_i) begin
            mc_q   <= '0;
            bclk_o <= 1'b0;
            rise_o <= 1'b0;
            fall_o <= 1'b0;
        end else begin
            mc_q   <= mc_nx;
            bclk_o <= (mc_nx >= half);
            rise_o <= (mc_nx == half);
            fall_o <= wrap_o;
        end
    end

    p_count_range_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        mc_q < div_i);
    p_rise_edge_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        rise_o |-> (bclk_o && !$past(bclk_o)));
    p_fall_edge_r3: assert property (@(posedge clk_i) disable iff (rst_i || clr_i)
        $fell(bclk_o) |-> fall_o);
endmodule

// File: rtl/aclk_frame_ctr.sv
module aclk_frame_ctr #(
    parameter int W = aclk_pkg::LEN_W
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         clr_i,
    input  logic         step_i,
    input  logic [W-1:0] len_i,
    output logic         last_o,
    output logic         ws_o,
    output logic         ws_rise_o,
    output logic         start_o
);
    logic [W-1:0] bc_q;
    logic [W-1:0] bc_nx;
    logic [W-1:0] half;

    assign half   = len_i >> 1;
    assign last_o = (bc_q == len_i - 1'b1);
    assign bc_nx  = last_o ? '0 : bc_q + 1'b1;

    always_ff @(posedge clk_i) begin
        if (rst_i || clr_i) begin
            bc_q      <= '0;
            ws_o      <= 1'b0;
            ws_rise_o <= 1'b0;
            start_o   <= 1'b0;
        end else if (step_i) begin
            bc_q      <= bc_nx;
            ws_o      <= (bc_nx >= half);
            ws_rise_o <= (bc_nx == half);
            start_o   <= last_o;
        end else begin
            ws_rise_o <= 1'b0;
            start_o   <= 1'b0;
        end
    end

    p_ws_on_step_r2: assert property (@(posedge clk_i) disable iff (rst_i || clr_i)
        !$stable(ws_o) |-> $past(step_i));
    p_bit_range_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        bc_q < len_i);
endmodule

// File: rtl/audio_clk_div.sv
module audio_clk_div
    import aclk_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [CFG_W-1:0] cfg_i,
    output logic             mclk_o,
    output logic             bclk_o,
    output logic             ws_o,
    output logic             bclk_rise_o,
    output logic             bclk_fall_o,
    output logic             ws_rise_o,
    output logic             frame_start_o,
    output logic             cfg_err_o
);
    cfg_t   cfg;
    ratio_t req_ratio;
    ratio_t cur_ratio;
    logic   req_bad;
    logic   active;
    logic   bit_wrap;
    logic   last_bit;
    logic   frame_end;
    logic   run_q;
    logic   gate_q;

    assign cfg       = cfg_t'(cfg_i);
    assign active    = cfg.clk_en && !cfg.soft_rst;
    assign frame_end = bit_wrap && last_bit;

    aclk_decode u_dec (
        .cfg_i   (cfg),
        .ratio_o (req_ratio),
        .bad_o   (req_bad)
    );

    // ratio in use: follows the request while idle, else only at a frame end
    always_ff @(posedge clk_i) begin
        if (rst_i)
            cur_ratio <= '{div: DEF_DIV, len: DEF_LEN};
        else if (!active || frame_end)
            cur_ratio <= req_ratio;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i || cfg.soft_rst)
            cfg_err_o <= 1'b0;
        else if (req_bad)
            cfg_err_o <= 1'b1;
    end

    aclk_bit_ctr #(.W(DIV_W)) u_bit (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .clr_i  (!active),
        .div_i  (cur_ratio.div),
        .wrap_o (bit_wrap),
        .bclk_o (bclk_o),
        .rise_o (bclk_rise_o),
        .fall_o (bclk_fall_o)
    );

    aclk_frame_ctr #(.W(LEN_W)) u_frm (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .clr_i     (!active),
        .step_i    (bit_wrap),
        .len_i     (cur_ratio.len),
        .last_o    (last_bit),
        .ws_o      (ws_o),
        .ws_rise_o (ws_rise_o),
        .start_o   (frame_start_o)
    );

    // gate enable moves only while the master clock is low
    always_ff @(posedge clk_i) begin
        if (rst_i) run_q <= 1'b0;
        else       run_q <= active;
    end

    always_ff @(negedge clk_i) begin
        gate_q <= run_q;
    end

    assign mclk_o = clk_i & gate_q;

    p_ratio_hold_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        (active && !frame_end) |=> $stable(cur_ratio));
    p_err_sticky_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        (cfg_err_o && !cfg.soft_rst) |=> cfg_err_o);
    p_idle_quiet_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        !cfg.clk_en |=> (!bclk_o && !ws_o && !frame_start_o));
    p_srst_quiet_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        cfg.soft_rst |=> (!bclk_o && !ws_o && !cfg_err_o && !bclk_rise_o));
    p_strobe_excl_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        !(bclk_rise_o && bclk_fall_o));
endmodule

// File: tb/audio_clk_div_test.sv
module audio_clk_div_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [9:0] cfg = '0;
    logic mclk_o, bclk_o, ws_o, bclk_rise_o, bclk_fall_o, ws_rise_o, frame_start_o, cfg_err_o;

    audio_clk_div uut (
        .clk_i(clk), .rst_i(rst), .cfg_i(cfg),
        .mclk_o(mclk_o), .bclk_o(bclk_o), .ws_o(ws_o),
        .bclk_rise_o(bclk_rise_o), .bclk_fall_o(bclk_fall_o),
        .ws_rise_o(ws_rise_o), .frame_start_o(frame_start_o),
        .cfg_err_o(cfg_err_o)
    );

    always #10 clk = ~clk;   // 50 MHz

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    string tag = "R9";

    // reference state computed from the requirements
    int m_mc = 0, m_bc = 0, m_d = 4, m_f = 64;
    bit m_err = 0, m_bclk = 0, m_ws = 0, m_br = 0, m_bf = 0, m_wr = 0, m_fs = 0;
    bit m_mclk = 0, prev_act = 0;
    bit got_fs = 0;
    int rise_cnt = 0;

    function automatic int bdiv(int c);
        return (c == 5) ? 8 : 4;
    endfunction

    function automatic int flen(int c);
        case (c)
            0: return 16;
            1: return 32;
            2: return 48;
            3: return 64;
            4: return 128;
            5: return 256;
            6: return 8;
            default: return 64;
        endcase
    endfunction

    function automatic logic [9:0] mk(bit srst, bit en, int f, int b);
        return {srst, en, 1'b0, 3'(f), 4'(b)};
    endfunction

    task automatic check(string req, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic model();
        bit act, bad, wrapm, lastm;
        act = cfg[8] && !cfg[9];
        bad = !(cfg[3:0] == 4'd3 || cfg[3:0] == 4'd5) || cfg[6:4] == 3'd7 || cfg[7];
        m_mclk = prev_act;
        m_br = 0; m_bf = 0; m_wr = 0; m_fs = 0;
        if (rst) begin
            m_mc = 0; m_bc = 0; m_d = 4; m_f = 64; m_err = 0;
            m_bclk = 0; m_ws = 0;
            prev_act = 0;
        end else begin
            if (cfg[9]) m_err = 0;
            else if (bad) m_err = 1;
            if (!act) begin
                m_mc = 0; m_bc = 0; m_bclk = 0; m_ws = 0;
                m_d = bdiv(int'(cfg[3:0])); m_f = flen(int'(cfg[6:4]));
            end else begin
                wrapm = (m_mc == m_d - 1);
                m_mc = wrapm ? 0 : m_mc + 1;
                m_bclk = (m_mc >= m_d / 2);
                m_br = (m_mc == m_d / 2);
                m_bf = wrapm;
                if (wrapm) begin
                    lastm = (m_bc == m_f - 1);
                    m_bc = lastm ? 0 : m_bc + 1;
                    m_ws = (m_bc >= m_f / 2);
                    m_wr = (m_bc == m_f / 2);
                    m_fs = lastm;
                    if (lastm) begin
                        m_d = bdiv(int'(cfg[3:0])); m_f = flen(int'(cfg[6:4]));
                    end
                end
            end
            prev_act = act;
        end
    endtask

    task automatic step();
        @(posedge clk);
        model();
        #5;
        check(tag,
              int'({mclk_o, bclk_o, ws_o, bclk_rise_o, bclk_fall_o, ws_rise_o, frame_start_o, cfg_err_o}),
              int'({m_mclk, m_bclk, m_ws, m_br, m_bf, m_wr, m_fs, m_err}),
              "outputs {mclk,bclk,ws,brise,bfall,wsrise,fstart,err}");
        got_fs = frame_start_o;
        if (bclk_rise_o) rise_cnt++;
        @(negedge clk);
    endtask

    task automatic wait_frame(output int n);
        n = 0;
        do begin
            step();
            n++;
        end while (!got_fs && n < 6000);
    endtask

    // one idle cycle with the new codes, then enable
    task automatic apply(int f, int b);
        cfg = mk(0, 0, f, b);
        step();
        cfg = mk(0, 1, f, b);
    endtask

    initial begin
        int n;
        rst = 1'b1;
        cfg = '0;
        repeat (2) begin
            @(posedge clk);
            @(negedge clk);
        end
        tag = "R9";
        repeat (2) step();
        check("R9", int'({bclk_o, ws_o, frame_start_o, cfg_err_o}), 0, "outputs in reset");
        rst = 1'b0;

        // sweep of every supported ratio pair
        for (int b = 0; b < 2; b++) begin
            for (int f = 0; f < 7; f++) begin
                int bc = (b != 0) ? 5 : 3;
                tag = "R1 R2 R3";
                apply(f, bc);
                wait_frame(n);
                check("R2", n, bdiv(bc) * flen(f), "cycles to first frame end");
                rise_cnt = 0;
                wait_frame(n);
                check("R2", n, bdiv(bc) * flen(f), "frame period in cycles");
                check("R1", rise_cnt, flen(f), "bit clocks per frame");
                cfg = mk(0, 0, f, bc);
                tag = "R4";
                repeat (3) step();
                check("R4", int'({mclk_o, bclk_o, ws_o}), 0, "disabled outputs");
            end
        end

        // unsupported codes
        tag = "R6 R7";
        apply(7, 0);
        wait_frame(n);
        check("R6", n, 4 * 64, "fallback frame period");
        check("R7", int'(cfg_err_o), 1, "error after bad codes");
        apply(0, 9);
        wait_frame(n);
        check("R6", n, 4 * 16, "fallback bit-clock ratio");
        apply(3, 3);
        repeat (5) step();
        check("R7", int'(cfg_err_o), 1, "error stays set");
        tag = "R5 R7";
        cfg = mk(1, 1, 3, 3);
        repeat (3) step();
        check("R7", int'(cfg_err_o), 0, "soft reset clears error");
        check("R5", int'({bclk_o, ws_o}), 0, "soft reset quiets clocks");
        tag = "R7";
        cfg = mk(0, 0, 3, 3) | 10'h080;
        repeat (2) step();
        check("R7", int'(cfg_err_o), 1, "reserved bit flags error");
        cfg = mk(1, 0, 3, 3);
        step();

        // soft reset in the middle of a frame, then restart
        tag = "R5";
        apply(0, 5);
        repeat (20) step();
        cfg = mk(1, 1, 0, 5);
        repeat (2) step();
        check("R5", int'({bclk_o, ws_o, bclk_fall_o}), 0, "held by soft reset");
        cfg = mk(0, 1, 0, 5);
        wait_frame(n);
        check("R5", n, 8 * 16, "restart from frame start");

        // codes changed while running wait for the frame end
        tag = "R8";
        apply(0, 3);
        repeat (10) step();
        cfg = mk(0, 1, 1, 5);
        wait_frame(n);
        check("R8", n + 10, 4 * 16, "old ratio finishes its frame");
        wait_frame(n);
        check("R8", n, 8 * 32, "new ratio from next frame");

        // reset while running
        tag = "R9";
        rst = 1'b1;
        repeat (2) step();
        check("R9", int'({bclk_o, ws_o, bclk_rise_o, cfg_err_o}), 0, "reset mid-run");
        rst = 1'b0;
        cfg = mk(0, 0, 3, 3);
        repeat (3) step();

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual 0 expected 1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule